// File: doc/BRIEF.md
# Sample-Queue PWM Audio Generator

This block turns a stream of audio sample words into a pulse-width-modulated output pin. A free-running counter sets the length of one PWM period. Software pushes samples into a four-entry queue through a small register write port. At the end of every period, the block takes the oldest queued sample and uses it as the compare value for the next period. The pin stays high while the counter is below that compare value. When software falls behind and the queue runs dry, the last sample is held and a sticky underrun flag records the gap.

A second source, tone mode, produces a square wave with 50% duty. The pin inverts once every programmed number of PWM periods, and the queue is left untouched. An interrupt line tells software to refill the queue when the fill level drops to a programmable watermark or lower. An empty queue always meets that condition.

Top module: `pwm_audio_gen`

## Requirements
- R1: After reset the pin is low, the queue is empty (level 0, empty flag 1, full flag 0), and the underrun, overflow and interrupt outputs are 0.
- R2: A write to address 1 sets the counter top value P. While running, the counter steps 0,1,...,P and then returns to 0, so one period lasts P+1 cycles. While stopped (control bit 0 clear), the counter is held at 0 and the pin is low.
- R3: In sample mode (control bit 1 clear) the pin is high exactly while the counter is below the active compare value. The compare value is 0 after reset, so the first period is entirely low.
- R4: At the last cycle of each period in sample mode, the oldest queued sample is removed and becomes the compare value for the next period. Samples play in the order they were written.
- R5: If the queue is empty at the end of a period in sample mode, the compare value is kept and the underrun flag becomes 1. The flag stays 1 until it is cleared.
- R6: A write to address 0 queues a sample. A write while the queue is full is dropped: the level and the queued contents are unchanged, and the overflow flag becomes 1 and stays set.
- R7: A write to address 2 with bit 7 set clears both sticky flags. If a flag is set and cleared in the same cycle, the set takes effect.
- R8: In tone mode (control bit 1 set), the pin starts low when running begins and inverts after every N complete periods, where N is written at address 3. N=0 acts as 1. No sample is removed from the queue in tone mode.
- R9: The interrupt output is high exactly when control bit 2 is set and the queue level is at or below the watermark held in control bits 6:4.
- R10: The level output gives the number of queued samples, 0 to 4. The full flag is 1 at level 4 and the empty flag is 1 at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 sample, 1 counter top, 2 control, 3 tone divider |
| wr_data | input | 16 | Write data |
| pwm_o | output | 1 | PWM output pin |
| fifo_level_o | output | 3 | Number of queued samples |
| fifo_full_o | output | 1 | Queue holds four samples |
| fifo_empty_o | output | 1 | Queue holds no sample |
| underrun_o | output | 1 | Sticky: a period ended with the queue empty |
| overflow_o | output | 1 | Sticky: a sample write was dropped because the queue was full |
| irq_o | output | 1 | Refill request |

## Verification
Some properties are checked on every cycle. The queue level never exceeds its depth, and the full and empty flags are never both set. A dropped write leaves the level unchanged and raises overflow. An end of period with an empty queue raises underrun. Samples are removed only at the end of a period and never in tone mode. The pin is low while stopped or while the compare value is zero. An enabled interrupt is asserted whenever the queue is empty. Other behaviour can only be shown by the bench's scenarios: the exact high time within each period, the order in which samples are played, repetition of the last sample after a drain, the tone half-period length, and the watermark threshold.

// File: rtl/pwm_audio_pkg.sv
package pwm_audio_pkg;

  // Register select codes on the write port
  typedef enum logic [1:0] {
    REG_SAMPLE = 2'd0,
    REG_PERIOD = 2'd1,
    REG_CTRL   = 2'd2,
    REG_TONE   = 2'd3
  } reg_sel_e;

  // Control word bit positions
  localparam int CTL_RUN    = 0;
  localparam int CTL_TONE   = 1;
  localparam int CTL_IRQ    = 2;
  localparam int CTL_WM_LSB = 4;
  localparam int CTL_CLR    = 7;

  // Output source selection
  typedef enum logic {
    SRC_SAMPLE = 1'b0,
    SRC_TONE   = 1'b1
  } src_e;

endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
  parameter  int W     = 16,
  parameter  int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [W-1:0]     push_data,
  input  logic             pop_req,
  output logic [W-1:0]     head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             push_acc,
  output logic             pop_acc
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);
  assign push_acc = push_req & ~full;
  assign pop_acc  = pop_req & ~empty;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_acc) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_acc)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_acc, pop_acc})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  // A top lowered below the current count ends the period at once
  assign wrap = run & (cnt >= top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || wrap)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pwm_tone_div.sv
module pwm_tone_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             wrap,
  input  logic [DIV_W-1:0] div,
  output logic             tone,
  output logic             toggle
);

  logic [DIV_W-1:0] nper;

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  assign toggle = active & wrap & (nper >= eff_div(div) - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nper <= '0;
      tone <= 1'b0;
    end else if (!active) begin
      nper <= '0;
      tone <= 1'b0;
    end else if (toggle) begin
      nper <= '0;
      tone <= ~tone;
    end else if (wrap) begin
      nper <= nper + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_audio_gen.sv
module pwm_audio_gen #(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 4,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_o,
  output logic [LVL_W-1:0]  fifo_level_o,
  output logic              fifo_full_o,
  output logic              fifo_empty_o,
  output logic              underrun_o,
  output logic              overflow_o,
  output logic              irq_o
);
  import pwm_audio_pkg::*;

  reg_sel_e          sel;
  logic              wr_sample, wr_period, wr_ctrl, wr_tone;
  logic [DATA_W-1:0] period_q, div_q, cmp_q, cnt_w, head_w;
  logic              run_q, irq_en_q;
  src_e              src_q;
  logic [LVL_W-1:0]  wm_q;
  logic              wrap_w, push_acc_w, pop_acc_w, pop_req_w;
  logic              tone_w, toggle_w, flag_clr_w, underrun_evt, overflow_evt;

  function automatic logic pwm_level(input logic [DATA_W-1:0] c,
                                     input logic [DATA_W-1:0] cmp);
    return c < cmp;
  endfunction

  assign sel       = reg_sel_e'(wr_addr);
  assign wr_sample = wr_en & (sel == REG_SAMPLE);
  assign wr_period = wr_en & (sel == REG_PERIOD);
  assign wr_ctrl   = wr_en & (sel == REG_CTRL);
  assign wr_tone   = wr_en & (sel == REG_TONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '1;
      div_q    <= DATA_W'(1);
      run_q    <= 1'b0;
      src_q    <= SRC_SAMPLE;
      irq_en_q <= 1'b0;
      wm_q     <= '0;
    end else begin
      if (wr_period) period_q <= wr_data;
      if (wr_tone)   div_q    <= wr_data;
      if (wr_ctrl) begin
        run_q    <= wr_data[CTL_RUN];
        src_q    <= src_e'(wr_data[CTL_TONE]);
        irq_en_q <= wr_data[CTL_IRQ];
        wm_q     <= wr_data[CTL_WM_LSB +: LVL_W];
      end
    end
  end

  pwm_period_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q),
    .top  (period_q),
    .cnt  (cnt_w),
    .wrap (wrap_w)
  );

  assign pop_req_w = wrap_w & (src_q == SRC_SAMPLE);

  pwm_sample_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (wr_sample),
    .push_data(wr_data),
    .pop_req  (pop_req_w),
    .head     (head_w),
    .level    (fifo_level_o),
    .full     (fifo_full_o),
    .empty    (fifo_empty_o),
    .push_acc (push_acc_w),
    .pop_acc  (pop_acc_w)
  );

  pwm_tone_div #(.DIV_W(DATA_W)) u_tone (
    .clk   (clk),
    .rst_n (rst_n),
    .active(run_q & (src_q == SRC_TONE)),
    .wrap  (wrap_w),
    .div   (div_q),
    .tone  (tone_w),
    .toggle(toggle_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cmp_q <= '0;
    else if (pop_acc_w) cmp_q <= head_w;
  end

  assign flag_clr_w   = wr_ctrl & wr_data[CTL_CLR];
  assign underrun_evt = pop_req_w & fifo_empty_o;
  assign overflow_evt = wr_sample & ~push_acc_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underrun_o <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      if (underrun_evt)    underrun_o <= 1'b1;
      else if (flag_clr_w) underrun_o <= 1'b0;
      if (overflow_evt)    overflow_o <= 1'b1;
      else if (flag_clr_w) overflow_o <= 1'b0;
    end
  end

  assign pwm_o = run_q & ((src_q == SRC_TONE) ? tone_w : pwm_level(cnt_w, cmp_q));
  assign irq_o = irq_en_q & (fifo_level_o <= wm_q);

endmodule

// File: rtl/pwm_audio_chk.sv
module pwm_audio_chk #(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 4,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              tone_mode,
  input logic              irq_en,
  input logic              wrap,
  input logic              push_req,
  input logic              pop_acc,
  input logic              full,
  input logic              empty,
  input logic [LVL_W-1:0]  level,
  input logic [DATA_W-1:0] cmp,
  input logic              underrun,
  input logic              overflow,
  input logic              pwm,
  input logic              irq
);

  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R6
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_acc) |=> (level == $past(level)) && overflow);

  // R5
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !tone_mode && empty) |=> underrun);

  // R4
  pop_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_acc |-> wrap);

  // R8
  tone_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tone_mode |-> !pop_acc);

  // R2
  stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !pwm);

  // R3
  zero_cmp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tone_mode && cmp == '0) |-> !pwm);

  // R9
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && empty) |-> irq);

endmodule

bind pwm_audio_gen pwm_audio_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run_q),
  .tone_mode(src_q == pwm_audio_pkg::SRC_TONE),
  .irq_en   (irq_en_q),
  .wrap     (wrap_w),
  .push_req (wr_sample),
  .pop_acc  (pop_acc_w),
  .full     (fifo_full_o),
  .empty    (fifo_empty_o),
  .level    (fifo_level_o),
  .cmp      (cmp_q),
  .underrun (underrun_o),
  .overflow (overflow_o),
  .pwm      (pwm_o),
  .irq      (irq_o)
);

// File: tb/sim_pwm_audio_gen.sv
module sim_pwm_audio_gen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_o, fifo_full_o, fifo_empty_o, underrun_o, overflow_o, irq_o;
  logic [2:0]  fifo_level_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_audio_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_o(pwm_o), .fifo_level_o(fifo_level_o), .fifo_full_o(fifo_full_o),
    .fifo_empty_o(fifo_empty_o), .underrun_o(underrun_o), .overflow_o(overflow_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Count high cycles over n cycles starting at the current negedge
  task automatic measure(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      hi += int'(pwm_o);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 pwm", pwm_o, 0);
    chk("R1 level", fifo_level_o, 0);
    chk("R1 empty", fifo_empty_o, 1);
    chk("R1 full", fifo_full_o, 0);
    chk("R1 underrun", underrun_o, 0);
    chk("R1 overflow", overflow_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_fill_overflow;
    reg_write(2'd0, 16'd3);
    reg_write(2'd0, 16'd7);
    chk("R10 level two", fifo_level_o, 2);
    reg_write(2'd0, 16'd0);
    reg_write(2'd0, 16'd10);
    chk("R10 level four", fifo_level_o, 4);
    chk("R10 full", fifo_full_o, 1);
    chk("R6 no overflow yet", overflow_o, 0);
    reg_write(2'd0, 16'd5);
    chk("R6 overflow set", overflow_o, 1);
    chk("R6 level kept", fifo_level_o, 4);
  endtask

  task automatic t_playback;
    int hi;
    reg_write(2'd1, 16'd9);
    reg_write(2'd2, 16'h0001);
    measure(10, hi); chk("R3 first period low", hi, 0);
    chk("R4 one popped", fifo_level_o, 3);
    measure(10, hi); chk("R4 sample 3", hi, 3);
    measure(10, hi); chk("R4 sample 7", hi, 7);
    measure(10, hi); chk("R3 sample 0", hi, 0);
    chk("R5 no underrun yet", underrun_o, 0);
    chk("R10 empty", fifo_empty_o, 1);
    measure(10, hi); chk("R3 sample above top", hi, 10);
    chk("R5 underrun set", underrun_o, 1);
    measure(10, hi); chk("R5 repeat, R6 dropped sample", hi, 10);
    reg_write(2'd2, 16'h0000);
    chk("R2 stopped low", pwm_o, 0);
    chk("R5 sticky", underrun_o, 1);
    chk("R6 sticky", overflow_o, 1);
  endtask

  task automatic t_clear;
    reg_write(2'd2, 16'h0080);
    chk("R7 underrun cleared", underrun_o, 0);
    chk("R7 overflow cleared", overflow_o, 0);
  endtask

  task automatic t_irq;
    reg_write(2'd2, 16'h0014);              // irq on, watermark 1
    chk("R9 irq at level 0", irq_o, 1);
    reg_write(2'd0, 16'd2);
    chk("R9 irq at watermark", irq_o, 1);
    reg_write(2'd0, 16'd2);
    chk("R9 irq above watermark", irq_o, 0);
    reg_write(2'd2, 16'h0004);              // watermark 0
    chk("R9 irq wm0 level2", irq_o, 0);
    reg_write(2'd2, 16'h0010);              // irq off
    chk("R9 irq disabled", irq_o, 0);
  endtask

  task automatic t_tone;
    int hi;
    reg_write(2'd1, 16'd3);
    reg_write(2'd3, 16'd2);
    reg_write(2'd2, 16'h0003);
    measure(8, hi); chk("R8 first half low", hi, 0);
    measure(8, hi); chk("R8 second half high", hi, 8);
    measure(8, hi); chk("R8 third half low", hi, 0);
    chk("R8 queue untouched", fifo_level_o, 2);
    chk("R8 no underrun", underrun_o, 0);
    reg_write(2'd2, 16'h0000);
    reg_write(2'd3, 16'd0);
    reg_write(2'd2, 16'h0003);
    measure(4, hi); chk("R8 div0 low", hi, 0);
    measure(4, hi); chk("R8 div0 high", hi, 4);
    reg_write(2'd2, 16'h0000);
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_overflow();
    t_playback();
    t_clear();
    t_irq();
    t_tone();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule